// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers 32 level-sensitive interrupt lines from peripherals and presents them to a parent interrupt controller as four summary outputs. Each output stands for a group of eight neighbouring lines: group g covers source bits [8g+7:8g]. A group output is high when at least one line in its group is both active and enabled. The output comes from a register, so it follows the sources one clock later.

Software changes the enable mask only through two write-only views. A write to the set view turns on every bit written as one. A write to the clear view turns off every bit written as one. Bits written as zero keep their value in both views, so a driver can change one line without a read-modify-write. The status view returns the sources that are active and enabled. The block stores no pending state: a line counts only while its peripheral holds it high.

The register access is a single-cycle strobe interface with a 4-bit byte offset. Reads are combinational in the cycle the read strobe is high.

Top module: `intr_combiner`

## Requirements
- R1: After reset the enable mask is all zeros and every group output is low, even when sources are high.
- R2: A write to offset 0x0 sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value. The new mask is visible from the next clock.
- R3: A write to offset 0x4 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read at offset 0x0 or at offset 0x4 returns the current 32-bit enable mask.
- R5: A read at offset 0xC returns the source lines ANDed with the enable mask, with bit i standing for source line i.
- R6: Group output g is the OR of (source AND enable) over bits [8g+7:8g], as sampled at the previous rising clock edge.
- R7: There is no latching. A group output falls one clock after its last enabled active source is deasserted or disabled.
- R8: A write to any offset other than 0x0 or 0x4 (including 0xC) leaves the enable mask unchanged. A read at any offset other than 0x0, 0x4 or 0xC returns zero.
- R9: The read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; zero when no valid read is in progress |
| grp_irq | output | 4 | One registered summary interrupt for each group of eight lines |

## Verification
The hardest case to reach is a group output falling because its enable was removed while the source stays high. The clear write takes effect at one edge, and the output register only sees the new mask at the edge after that. The bench holds a source high, enables it, and then clears it. It checks the output both one cycle and two cycles after the clear write, so an off-by-one in either register shows up. A randomized series of set writes, clear writes and source patterns then compares the status view and all four outputs against a mask model kept in the bench.

// File: rtl/intr_combiner.sv
module intr_combiner #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*GROUP_W-1:0] src_i,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [GROUPS*GROUP_W-1:0] wdata,
  output logic [GROUPS*GROUP_W-1:0] rdata,
  output logic [GROUPS-1:0]         grp_irq
);
  localparam int W = GROUPS * GROUP_W;
  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'hC);

  logic [W-1:0]      en_q;
  logic [W-1:0]      active;
  logic [GROUPS-1:0] grp_d;

  assign active = src_i & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_en && addr == OFS_SET)
      en_q <= en_q | wdata;
    else if (wr_en && addr == OFS_CLR)
      en_q <= en_q & ~wdata;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_d[g] = |active[g*GROUP_W +: GROUP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_irq <= '0;
    else        grp_irq <= grp_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_SET, OFS_CLR: rdata = en_q;
        OFS_STAT:         rdata = active;
        default:          rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_combiner_chk.sv
module intr_combiner_chk #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [GROUPS*GROUP_W-1:0] src_i,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [GROUPS*GROUP_W-1:0] wdata,
  input logic [GROUPS*GROUP_W-1:0] rdata,
  input logic [GROUPS-1:0]         grp_irq,
  input logic [GROUPS*GROUP_W-1:0] en_q
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(4'hC);

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((en_q & $past(wdata)) == '0));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_SET || addr == A_CLR)) |=> $stable(en_q));

  // R6
  grp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & en_q) != '0) |=> (grp_irq != '0));

  // R7
  grp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & en_q) == '0) |=> (grp_irq == '0));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != A_SET && addr != A_CLR && addr != A_ST) |-> (rdata == '0));

  // R5
  stat_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ST) |-> ((rdata & ~src_i) == '0));
endmodule

bind intr_combiner intr_combiner_chk #(
  .GROUPS(GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .grp_irq(grp_irq), .en_q(en_q)
);

// File: tb/intr_combiner_test.sv
`timescale 1ns/1ps
module intr_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_en = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  intr_combiner uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .grp_irq(grp_irq)
  );

  function automatic logic [3:0] grp_of(input logic [31:0] a);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |a[g*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    if (a == 4'h0) exp_en = exp_en | d;
    else if (a == 4'h4) exp_en = exp_en & ~d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 grp", {28'd0, grp_irq}, 32'd0);
    rd(4'h0, v); chk("R1 mask", v, 32'd0);
    rd(4'hC, v); chk("R1 status", v, 32'd0);
    set_src(32'd0);

    // R2 / R4: walking set
    for (int i = 0; i < 32; i++) begin
      wr(4'h0, 32'd1 << i);
      rd(4'h0, v); chk("R2 set walk", v, exp_en);
      rd(4'h4, v); chk("R4 clr view", v, exp_en);
    end
    // R3: clear one group at a time
    for (int g = 0; g < 4; g++) begin
      wr(4'h4, 32'hFF << (8*g));
      rd(4'h0, v); chk("R3 group clear", v, exp_en);
    end
    wr(4'h0, 32'hA5C3_0F96);
    wr(4'h4, 32'h0000_0000);
    rd(4'h0, v); chk("R3 zero clear", v, 32'hA5C3_0F96);
    wr(4'h0, 32'h0000_0000);
    rd(4'h0, v); chk("R2 zero set", v, 32'hA5C3_0F96);

    // R8: writes to other offsets, reads of holes
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) begin
        wr(4'(a), 32'hFFFF_FFFF);
        wr(4'(a), 32'h0);
        rd(4'h0, v); chk("R8 write ignored", v, exp_en);
      end
      if (a != 0 && a != 4 && a != 12) begin
        set_src(32'hFFFF_FFFF);
        rd(4'(a), v); chk("R8 hole read", v, 32'd0);
      end
    end
    // R9: idle read data
    @(negedge clk); addr = 4'h0; #1 chk("R9 idle", rdata, 32'd0);

    // R5 / R6: single source sweep with everything enabled
    wr(4'h0, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      set_src(32'd1 << i);
      chk("R6 single line", {28'd0, grp_irq}, {28'd0, grp_of(32'd1 << i)});
      rd(4'hC, v); chk("R5 status single", v, 32'd1 << i);
    end

    // R7: level drop and enable removal
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'd1 << 9);
    set_src(32'd1 << 9);
    chk("R7 asserted", {28'd0, grp_irq}, 32'd2);
    set_src(32'd0);
    chk("R7 source drop", {28'd0, grp_irq}, 32'd0);
    set_src(32'd1 << 9);
    chk("R7 reassert", {28'd0, grp_irq}, 32'd2);
    wr(4'h4, 32'd1 << 9);
    chk("R7 one cycle after clear", {28'd0, grp_irq}, 32'd2);
    @(negedge clk);
    chk("R7 after clear", {28'd0, grp_irq}, 32'd0);
    rd(4'hC, v); chk("R5 disabled line", v, 32'd0);

    // R5 / R6: random patterns against the model
    for (int k = 0; k < 200; k++) begin
      lfsr = nxt(lfsr); wr(4'h0, lfsr);
      lfsr = nxt(lfsr); wr(4'h4, lfsr & nxt(lfsr));
      lfsr = nxt(lfsr); set_src(lfsr);
      chk("R6 random", {28'd0, grp_irq}, {28'd0, grp_of(src_i & exp_en)});
      rd(4'hC, v); chk("R5 random", v, src_i & exp_en);
      rd(4'h0, v); chk("R4 random", v, exp_en);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule